// File: doc/BRIEF.md
# Speculative Store Queue with Load Forwarding

The block keeps executed stores in a circular queue until the core declares them retired, so that speculative stores never touch memory early. Dispatch reserves an entry in program order and gets back a sequence tag. Execute fills in the word address and the store data in any order and at any time, addressing the entry by the low bits of its tag. The core retires stores one at a time in program order. The oldest retired store is written to a plain memory write port, one store per cycle.

A branch mispredict or an exception rewinds the queue to a given tag. Every store holding that tag or a younger one is dropped and never reaches memory. Loads present the allocation tag that was current when they were dispatched, together with a word address. The queue answers in the same cycle. It returns the data of the youngest older store whose address is known and matches. It signals a stall if that store has no data yet, and it reports a miss when no older store matches, in which case the load takes its value from memory.

Occupancy is tracked by a three-state controller. In EMPTY the queue holds nothing. PARTIAL covers one to DEPTH-1 entries. FULL means DEPTH entries are held. The transitions are FILL (EMPTY to PARTIAL on an allocation), TOP (PARTIAL to FULL when the last free slot is taken), RELIEVE (FULL to PARTIAL on a drain or flush), EMPTY_OUT (PARTIAL or FULL to EMPTY when the last entry drains or is flushed) and HOLD (occupancy class unchanged).

Top module: `store_queue`

## Requirements
- R1: `mem_we` is high in a cycle exactly when the oldest entry is retired and not yet drained. `mem_addr` and `mem_data` then carry that store's address and data. The head advances by one per cycle, so stores reach memory in program order and only after retirement.
- R2: `al_tag` shows the tag the next allocation receives. Tags count up by one per accepted allocation, modulo 2*DEPTH, starting from 0 after reset.
- R3: `full` is high when DEPTH entries are held. An allocation request while `full` is high is ignored and `al_tag` does not advance, even if a drain happens in the same cycle.
- R4: A flush with tag F discards all entries with tag F or younger, so none of them is ever written to memory. The next allocation then receives tag F. An allocation request in the same cycle as a flush is ignored.
- R5: A load with tag T and address A sees only stores with tags older than T, searched from youngest to oldest among those with a valid address equal to A. If that store has valid data, `ld_hit` is 1 and `ld_data` is its data.
- R6: If the selected store has a valid address but no data, `ld_stall` is 1, `ld_hit` is 0 and `ld_data` is 0.
- R7: If no older store has a valid matching address, both `ld_hit` and `ld_stall` are 0. Stores with tags T or younger never affect the result.
- R8: A retire request while no allocated entry is unretired is ignored and causes no memory write.
- R9: After reset the queue is empty: `empty`=1, `full`=0, `mem_we`=0, `al_tag`=0.
- R10: A newly allocated entry has neither address nor data valid. An address or data left in a reused slot from an earlier, drained or flushed store never takes part in forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| al_valid | input | 1 | Allocation request from dispatch |
| al_tag | output | TW | Tag given to the next allocation |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| ea_valid | input | 1 | Address write from execute |
| ea_idx | input | PW | Entry index (tag low bits) for the address write |
| ea_addr | input | AW | Store word address |
| ed_valid | input | 1 | Data write from execute |
| ed_idx | input | PW | Entry index for the data write |
| ed_data | input | DW | Store data |
| ret_valid | input | 1 | Retire the oldest unretired store |
| fl_valid | input | 1 | Flush request |
| fl_tag | input | TW | First tag to discard |
| ld_valid | input | 1 | Load lookup request |
| ld_tag | input | TW | Allocation tag current at the load's dispatch |
| ld_addr | input | AW | Load word address |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_stall | output | 1 | Matching older store has no data yet |
| ld_data | output | DW | Forwarded data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |

## Verification
The collision of interest is a flush landing in the same cycle as a drain of the head entry. The drain must still write the retired store, while the flush rewinds the tail below the younger entries. A directed sequence retires the oldest store and then flushes the next tag exactly in the drain cycle. The random phase keeps hitting the same collision, along with loads that look up an entry in the cycle it drains. A behavioural model holds the queue as a list of tagged entries and checks the memory port, the flags, the next tag and the forwarding answer before every clock edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } occ_e;
endpackage

// File: rtl/sq_store.sv
module sq_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         al_we,
    input  logic [PW-1:0]                al_idx,
    input  logic                         ea_we,
    input  logic [PW-1:0]                ea_idx,
    input  logic [AW-1:0]                ea_addr,
    input  logic                         ed_we,
    input  logic [PW-1:0]                ed_idx,
    input  logic [DW-1:0]                ed_data,
    output logic [DEPTH-1:0]             av_o,
    output logic [DEPTH-1:0]             dv_o,
    output logic [DEPTH-1:0][AW-1:0]     addr_o,
    output logic [DEPTH-1:0][DW-1:0]     data_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [PW-1:0] IDX = PW'(i);

        // valid flags: allocation clears, later in the block so it wins
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                av_o[i] <= 1'b0;
                dv_o[i] <= 1'b0;
            end else begin
                if (ea_we && ea_idx == IDX) av_o[i] <= 1'b1;
                if (ed_we && ed_idx == IDX) dv_o[i] <= 1'b1;
                if (al_we && al_idx == IDX) begin
                    av_o[i] <= 1'b0;
                    dv_o[i] <= 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (ea_we && ea_idx == IDX) addr_o[i] <= ea_addr;
            if (ed_we && ed_idx == IDX) data_o[i] <= ed_data;
        end
    end
endmodule

// File: rtl/sq_fwd.sv
module sq_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int TW   = PW + 1
) (
    input  logic                     ld_valid,
    input  logic [TW-1:0]            ld_tag,
    input  logic [AW-1:0]            ld_addr,
    input  logic [TW-1:0]            head,
    input  logic [DEPTH-1:0]         av,
    input  logic [DEPTH-1:0]         dv,
    input  logic [DEPTH-1:0][AW-1:0] addr,
    input  logic [DEPTH-1:0][DW-1:0] data,
    output logic                     hit,
    output logic                     stall,
    output logic [DW-1:0]            fdata
);
    logic [TW-1:0] diff;
    logic [TW-1:0] nold;
    logic [PW-1:0] idx;
    logic          found;
    logic          fdv;
    logic [DW-1:0] fsel;

    always_comb begin
        diff  = ld_tag - head;
        // a load older than the head has no older store left in the queue
        nold  = (diff > TW'(DEPTH)) ? '0 : diff;
        found = 1'b0;
        fdv   = 1'b0;
        fsel  = '0;
        idx   = '0;
        // walk from oldest to youngest; the last match is the youngest
        for (int k = 0; k < DEPTH; k++) begin
            idx = head[PW-1:0] + PW'(k);
            if (TW'(k) < nold && av[idx] && addr[idx] == ld_addr) begin
                found = 1'b1;
                fdv   = dv[idx];
                fsel  = data[idx];
            end
        end
        hit   = ld_valid && found && fdv;
        stall = ld_valid && found && !fdv;
        fdata = hit ? fsel : '0;
    end
endmodule

// File: rtl/store_queue.sv
module store_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int TW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          al_valid,
    output logic [TW-1:0] al_tag,
    output logic          full,
    output logic          empty,
    input  logic          ea_valid,
    input  logic [PW-1:0] ea_idx,
    input  logic [AW-1:0] ea_addr,
    input  logic          ed_valid,
    input  logic [PW-1:0] ed_idx,
    input  logic [DW-1:0] ed_data,
    input  logic          ret_valid,
    input  logic          fl_valid,
    input  logic [TW-1:0] fl_tag,
    input  logic          ld_valid,
    input  logic [TW-1:0] ld_tag,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic          ld_stall,
    output logic [DW-1:0] ld_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    import sq_pkg::*;

    occ_e          qst, qst_n;
    logic [TW-1:0] head, tail, rp;
    logic [TW-1:0] head_n, tail_n, rp_n, cnt_n;
    logic          acc, ret_ok, drain;

    logic [DEPTH-1:0]         av, dv;
    logic [DEPTH-1:0][AW-1:0] addr;
    logic [DEPTH-1:0][DW-1:0] data;

    // pointer and next-state logic
    always_comb begin
        acc    = al_valid && !full && !fl_valid;
        ret_ok = ret_valid && (rp != tail);
        drain  = (head != rp);
        tail_n = fl_valid ? fl_tag : (tail + TW'(acc));
        head_n = head + TW'(drain);
        rp_n   = rp + TW'(ret_ok);
        cnt_n  = tail_n - head_n;
        qst_n  = qst;
        unique case (qst)
            Q_EMPTY: begin
                if (cnt_n != '0) qst_n = Q_PART;                    // FILL
            end
            Q_PART: begin
                if (cnt_n == '0)              qst_n = Q_EMPTY;      // EMPTY_OUT
                else if (cnt_n == TW'(DEPTH)) qst_n = Q_FULL;       // TOP
            end
            Q_FULL: begin
                if (cnt_n == '0)              qst_n = Q_EMPTY;      // EMPTY_OUT
                else if (cnt_n != TW'(DEPTH)) qst_n = Q_PART;       // RELIEVE
            end
            default: qst_n = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qst  <= Q_EMPTY;
            head <= '0;
            tail <= '0;
            rp   <= '0;
        end else begin
            qst  <= qst_n;
            head <= head_n;
            tail <= tail_n;
            rp   <= rp_n;
        end
    end

    // outputs
    always_comb begin
        unique case (qst)
            Q_EMPTY: begin empty = 1'b1; full = 1'b0; end
            Q_PART:  begin empty = 1'b0; full = 1'b0; end
            Q_FULL:  begin empty = 1'b0; full = 1'b1; end
            default: begin empty = 1'b1; full = 1'b0; end
        endcase
        al_tag   = tail;
        mem_we   = drain;
        mem_addr = addr[head[PW-1:0]];
        mem_data = data[head[PW-1:0]];
    end

    sq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .al_we   (acc),
        .al_idx  (tail[PW-1:0]),
        .ea_we   (ea_valid),
        .ea_idx  (ea_idx),
        .ea_addr (ea_addr),
        .ed_we   (ed_valid),
        .ed_idx  (ed_idx),
        .ed_data (ed_data),
        .av_o    (av),
        .dv_o    (dv),
        .addr_o  (addr),
        .data_o  (data)
    );

    sq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .ld_valid (ld_valid),
        .ld_tag   (ld_tag),
        .ld_addr  (ld_addr),
        .head     (head),
        .av       (av),
        .dv       (dv),
        .addr     (addr),
        .data     (data),
        .hit      (ld_hit),
        .stall    (ld_stall),
        .fdata    (ld_data)
    );
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int TW   = PW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          al_valid,
    input logic [TW-1:0] al_tag,
    input logic          full,
    input logic          empty,
    input logic          fl_valid,
    input logic [TW-1:0] fl_tag,
    input logic          ld_hit,
    input logic          ld_stall,
    input logic          mem_we
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !fl_valid) |=> (al_tag == $past(al_tag))); // R3

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (al_valid && !full && !fl_valid) |=> (al_tag == $past(al_tag) + TW'(1))); // R2

    AST_FLUSH_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |=> (al_tag == $past(fl_tag))); // R4

    AST_DRAIN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !empty); // R1

    AST_HIT_OR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_stall)); // R6
endmodule

bind store_queue sq_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .al_valid (al_valid),
    .al_tag   (al_tag),
    .full     (full),
    .empty    (empty),
    .fl_valid (fl_valid),
    .fl_tag   (fl_tag),
    .ld_hit   (ld_hit),
    .ld_stall (ld_stall),
    .mem_we   (mem_we)
);

// File: tb/sim_store_queue.sv
`timescale 1ns/1ps
module sim_store_queue;
    localparam int D  = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int PW = 3;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          al_valid = 0, ea_valid = 0, ed_valid = 0, ret_valid = 0, fl_valid = 0, ld_valid = 0;
    logic [PW-1:0] ea_idx = 0, ed_idx = 0;
    logic [AW-1:0] ea_addr = 0, ld_addr = 0;
    logic [DW-1:0] ed_data = 0;
    logic [TW-1:0] fl_tag = 0, ld_tag = 0;
    logic [TW-1:0] al_tag;
    logic          full, empty, ld_hit, ld_stall, mem_we;
    logic [DW-1:0] ld_data, mem_data;
    logic [AW-1:0] mem_addr;

    store_queue #(.DEPTH(D), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .al_valid(al_valid), .al_tag(al_tag),
        .full(full), .empty(empty), .ea_valid(ea_valid), .ea_idx(ea_idx),
        .ea_addr(ea_addr), .ed_valid(ed_valid), .ed_idx(ed_idx), .ed_data(ed_data),
        .ret_valid(ret_valid), .fl_valid(fl_valid), .fl_tag(fl_tag),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
        .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    typedef struct {
        int          tag;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit          av;
        bit          dv;
    } ent_t;

    ent_t q[$];
    int nxt = 0;      // next tag, unbounded
    int hd  = 0;      // tag of oldest held entry
    int nret = 0;     // retired, not yet drained
    int flT = 0;      // flush tag as integer
    int ldT = 0;      // load tag as integer
    int vecs = 0, mis = 0;
    bit last_flush = 0;
    bit x_r8 = 0, x_r10 = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            mis++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check();
        bit ef, eh, es;
        logic [DW-1:0] ed;
        string lr;
        chk(full == (q.size() == D), "R3 full", full, q.size() == D);
        chk(empty == (q.size() == 0), "R9 empty", empty, q.size() == 0);
        if (last_flush) chk(al_tag == TW'(nxt % 16), "R4 tag after flush", al_tag, nxt % 16);
        else            chk(al_tag == TW'(nxt % 16), "R2 next tag", al_tag, nxt % 16);
        chk(mem_we == (nret > 0), "R1 write strobe", mem_we, nret > 0);
        if (nret > 0) begin
            chk(mem_addr == q[0].a, "R1 write address", mem_addr, q[0].a);
            chk(mem_data == q[0].d, "R1 write data", mem_data, q[0].d);
        end
        if (x_r8) chk(mem_we == 1'b0, "R8 ignored retire", mem_we, 0);
        if (ld_valid) begin
            ef = 0; eh = 0; es = 0; ed = '0;
            for (int j = q.size() - 1; j >= 0; j--) begin
                if (!ef && q[j].tag < ldT && q[j].av && q[j].a == ld_addr) begin
                    ef = 1; eh = q[j].dv; es = !q[j].dv; ed = q[j].dv ? q[j].d : '0;
                end
            end
            lr = !ef ? "R7 miss" : (eh ? "R5 forward" : "R6 stall");
            chk(ld_hit == eh, {lr, " hit"}, ld_hit, eh);
            chk(ld_stall == es, {lr, " stall"}, ld_stall, es);
            chk(ld_data == ed, {lr, " data"}, ld_data, ed);
            if (x_r10) chk(!ld_hit && !ld_stall, "R10 stale slot", {ld_hit, ld_stall}, 0);
        end
    endtask

    task automatic update();
        int  psz;
        bit  pfull, rok;
        psz   = q.size();
        pfull = (psz == D);
        rok   = ret_valid && (nret < psz);
        for (int j = 0; j < q.size(); j++) begin
            if (ea_valid && (q[j].tag % D) == ea_idx) begin q[j].av = 1; q[j].a = ea_addr; end
            if (ed_valid && (q[j].tag % D) == ed_idx) begin q[j].dv = 1; q[j].d = ed_data; end
        end
        if (nret > 0) begin
            void'(q.pop_front());
            nret--;
            hd++;
        end
        if (rok) nret++;
        if (fl_valid) begin
            while (q.size() > 0 && q[q.size()-1].tag >= flT) void'(q.pop_back());
            nxt = flT;
        end else if (al_valid && !pfull) begin
            ent_t e;
            e.tag = nxt; e.a = '0; e.d = '0; e.av = 0; e.dv = 0;
            q.push_back(e);
            nxt++;
        end
        last_flush = fl_valid;
    endtask

    task automatic tick();
        fl_tag = TW'(flT % 16);
        ld_tag = TW'(ldT % 16);
        #2;
        check();
        @(posedge clk);
        #1;
        update();
        @(negedge clk);
        al_valid = 0; ea_valid = 0; ed_valid = 0; ret_valid = 0;
        fl_valid = 0; ld_valid = 0; x_r8 = 0; x_r10 = 0;
    endtask

    task automatic wr_addr(input int tag, input int a);
        ea_valid = 1; ea_idx = PW'(tag % D); ea_addr = AW'(a);
    endtask
    task automatic wr_data(input int tag, input int d);
        ed_valid = 1; ed_idx = PW'(tag % D); ed_data = DW'(d);
    endtask
    task automatic load(input int t, input int a);
        ld_valid = 1; ldT = t; ld_addr = AW'(a);
    endtask

    task automatic rand_cycle();
        int sz, j, lo;
        sz = q.size();
        al_valid = ($urandom % 3) != 0;
        if (sz > 0) begin
            j = $urandom % sz;
            if (!q[j].av) wr_addr(q[j].tag, $urandom % 4);
            j = $urandom % sz;
            if (!q[j].dv) wr_data(q[j].tag, $urandom);
        end
        if (nret < sz && q[nret].av && q[nret].dv && ($urandom % 2) == 0) ret_valid = 1;
        if (($urandom % 12) == 0) begin
            lo = hd + nret + (ret_valid ? 1 : 0);
            if (lo <= nxt) begin
                fl_valid = 1;
                flT = lo + ($urandom % (nxt - lo + 1));
            end
        end
        if (($urandom % 4) != 0) load(hd + ($urandom % (nxt - hd + 1)), $urandom % 4);
    endtask

    initial begin
        #(8 * 200000);
        vecs++; mis++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, mis);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();                                // R9 reset state
        repeat (4) begin al_valid = 1; tick(); end   // tags 0..3
        wr_addr(0, 1); wr_data(0, 32'hA0); tick();
        wr_addr(2, 1); tick();
        wr_addr(1, 2); tick();
        load(3, 1); tick();                    // R6: tag2 has no data
        load(2, 1); tick();                    // R5: tag0
        load(1, 2); tick();                    // R7: tag1 is younger
        wr_data(2, 32'hB2); tick();
        load(3, 1); tick();                    // R5: youngest older wins
        ret_valid = 1; tick();                 // retire tag0
        fl_valid = 1; flT = 2; load(1, 1); tick();   // flush during drain of tag0
        wr_data(1, 32'hC1); ret_valid = 1; tick();
        tick();                                // tag1 drains
        ret_valid = 1; tick();                 // nothing to retire: R8
        x_r8 = 1; tick();
        al_valid = 1; tick();                  // tag2 reuses slot with stale addr 1
        x_r10 = 1; load(3, 1); tick();         // R10
        repeat (10) begin al_valid = 1; tick(); end  // fill past full: R3
        for (int n = 0; n < 4000; n++) begin
            rand_cycle();
            tick();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, mis);
        $finish;
    end
endmodule